// File: doc/BRIEF.md
# ADC Output Data Formatter

This block sits between the digital back end of a pipelined converter core and the output drivers. On every sample clock it accepts one raw offset-binary code together with the core's out-of-range flag. It recodes the code into the coding picked by a two-bit select and pushes the word, the range flag and the derived over-range and under-range bits through a fixed run of register stages. The result leaves the block with a data-valid strobe.

Recoding happens as a sample enters, so every word in flight keeps the format that was selected when it was captured. A small controller with three states decides when the strobe may rise. FILL counts samples after reset or after leaving power-down. RUN is the steady state. SLEEP is held while power-down is asserted. The transitions are FILL to RUN (the fifth sample since the count restarted has been captured), any state to SLEEP (power-down seen at an edge), and SLEEP to FILL (power-down seen low at an edge, and that edge's sample counts as the first). While power-down is high, every output is driven to zero at once. This is the on-chip stand-in for a high-impedance output.

Top module: `adc_out_fmt`

## Requirements
- R1: While reset is asserted, out_code, out_oor, out_over, out_under and out_valid are all zero.
- R2: With fmt_sel = 2'b00 (offset binary), out_code equals the captured code unchanged; 4095, 2048, 2047 and 0 come out as 4095, 2048, 2047 and 0.
- R3: With fmt_sel = 2'b01 (twos complement), out_code is the captured code with bit 11 inverted and bits 10..0 unchanged.
- R4: With fmt_sel = 2'b10 (Gray), out_code is the captured code b XOR (b shifted right by one).
- R5: fmt_sel = 2'b11 is treated exactly as offset binary.
- R6: There are five register stages: a code present at rising edge k is on out_code from edge k+4 on, and its range flag and decoded range bits appear in that same cycle.
- R7: The format is applied per sample at capture. A change of fmt_sel alters only samples captured at or after the edge that sees the new value, and never words already in the stages.
- R8: out_over is the range flag AND bit 11 of the offset-binary code, and out_under is the range flag AND the inverse of that bit, whatever the selected format. The two are never high together.
- R9: After reset is released, out_valid stays low until five samples have been captured, counting the first edge after release. After that it stays high on every cycle until power-down.
- R10: While pwr_dn is high, in the same cycle, out_code, out_oor, out_over, out_under and out_valid are all zero.
- R11: The first edge with pwr_dn low after power-down counts as the first of five refill samples, and out_valid stays low until the fifth.
- R12: out_oor is low for a sample captured with core_oor low and high for a sample captured with core_oor high, aligned as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| core_code | input | 12 | Raw offset-binary code from the converter core |
| core_oor | input | 1 | Out-of-range flag from the core for this code |
| fmt_sel | input | 2 | Output coding: 00 offset binary, 01 twos complement, 10 Gray, 11 offset binary |
| pwr_dn | input | 1 | Power-down; forces all outputs to zero |
| out_code | output | 12 | Formatted output word |
| out_oor | output | 1 | Range flag aligned with out_code |
| out_over | output | 1 | Input was above full scale |
| out_under | output | 1 | Input was below full scale |
| out_valid | output | 1 | Output word is valid |

## Verification
A controller stuck in FILL, or leaving it one sample early or late, shows as out_valid rising on the wrong cycle within five clocks of reset or of power-down release. A misrouted stage or a format applied at the output instead of at capture shows as out_code mismatching the word captured four edges earlier. This is caught by alternating fmt_sel every cycle, which exposes it on the first valid word. A range bit decoded from the recoded word instead of the raw MSB shows as a wrong out_over or out_under on the first out-of-range sample captured in twos complement or Gray.

// File: rtl/fmt_pkg.sv
`timescale 1ns/1ps
package fmt_pkg;

    typedef enum logic [1:0] {
        FMT_OFFS = 2'b00,
        FMT_TWOS = 2'b01,
        FMT_GRAY = 2'b10,
        FMT_ALT  = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        ST_FILL  = 2'b00,
        ST_RUN   = 2'b01,
        ST_SLEEP = 2'b10
    } st_e;

    typedef struct packed {
        logic flag;
        logic over;
        logic under;
    } rng_t;

    localparam int RNG_W = $bits(rng_t);

endpackage

// File: rtl/fmt_encode.sv
`timescale 1ns/1ps
module fmt_encode
    import fmt_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic [DW-1:0] raw_i,
    input  logic          oor_i,
    input  fmt_e          fmt_i,
    output logic [DW-1:0] word_o,
    output rng_t          rng_o
);
    localparam int MSB = DW - 1;

    always_comb begin
        unique case (fmt_i)
            FMT_TWOS: word_o = {~raw_i[MSB], raw_i[MSB-1:0]};
            FMT_GRAY: word_o = raw_i ^ (raw_i >> 1);
            FMT_OFFS: word_o = raw_i;
            FMT_ALT:  word_o = raw_i;
            default:  word_o = raw_i;
        endcase
    end

    // range bits always come from the untouched offset-binary MSB
    always_comb begin
        rng_o.flag  = oor_i;
        rng_o.over  = oor_i &  raw_i[MSB];
        rng_o.under = oor_i & ~raw_i[MSB];
    end

endmodule

// File: rtl/fmt_delay_line.sv
`timescale 1ns/1ps
module fmt_delay_line #(
    parameter int W     = 15,
    parameter int DEPTH = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_stg
        logic [W-1:0] r;
        if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r <= '0;
                else        r <= d_i;
            end
        end else begin : g_tail
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r <= '0;
                else        r <= g_stg[i-1].r;
            end
        end
    end

    assign q_o = g_stg[DEPTH-1].r;

endmodule

// File: rtl/fmt_ctrl.sv
`timescale 1ns/1ps
module fmt_ctrl
    import fmt_pkg::*;
#(
    parameter int LAT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_i,
    output logic run_o
);
    localparam int            CW   = $clog2(LAT + 1);
    localparam logic [CW-1:0] LAST = CW'(LAT - 1);
    localparam logic [CW-1:0] ONE  = CW'(1);

    st_e           st, st_nx;
    logic [CW-1:0] cnt, cnt_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_FILL;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    // next state
    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        if (pd_i) begin
            st_nx  = ST_SLEEP;
            cnt_nx = '0;
        end else begin
            unique case (st)
                ST_FILL: begin
                    if (cnt == LAST) st_nx = ST_RUN;
                    else             cnt_nx = cnt + ONE;
                end
                ST_RUN: begin
                    st_nx = ST_RUN;
                end
                ST_SLEEP: begin
                    st_nx  = ST_FILL;
                    cnt_nx = ONE;
                end
                default: begin
                    st_nx  = ST_FILL;
                    cnt_nx = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        run_o = (st == ST_RUN);
    end

    p_pd_enter_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pd_i |=> (st == ST_SLEEP));

    p_sleep_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SLEEP && !pd_i) |=> (st == ST_FILL && cnt == ONE));

    p_run_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && !pd_i) |=> (st == ST_RUN));

    p_fill_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FILL) |-> (cnt <= LAST));

endmodule

// File: rtl/adc_out_fmt.sv
`timescale 1ns/1ps
module adc_out_fmt
    import fmt_pkg::*;
#(
    parameter int DW  = 12,
    parameter int LAT = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] core_code,
    input  logic          core_oor,
    input  logic [1:0]    fmt_sel,
    input  logic          pwr_dn,
    output logic [DW-1:0] out_code,
    output logic          out_oor,
    output logic          out_over,
    output logic          out_under,
    output logic          out_valid
);
    localparam int PW = DW + RNG_W;

    logic [DW-1:0] enc_word;
    rng_t          enc_rng;
    logic [PW-1:0] pipe_in, pipe_out;
    logic [DW-1:0] dly_word;
    rng_t          dly_rng;
    logic          run;

    fmt_encode #(.DW(DW)) u_enc (
        .raw_i  (core_code),
        .oor_i  (core_oor),
        .fmt_i  (fmt_e'(fmt_sel)),
        .word_o (enc_word),
        .rng_o  (enc_rng)
    );

    assign pipe_in = {enc_word, enc_rng};

    fmt_delay_line #(.W(PW), .DEPTH(LAT)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pipe_in),
        .q_o   (pipe_out)
    );

    assign {dly_word, dly_rng} = pipe_out;

    fmt_ctrl #(.LAT(LAT)) u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .pd_i  (pwr_dn),
        .run_o (run)
    );

    always_comb begin
        if (pwr_dn) begin
            out_code  = '0;
            out_oor   = 1'b0;
            out_over  = 1'b0;
            out_under = 1'b0;
            out_valid = 1'b0;
        end else begin
            out_code  = dly_word;
            out_oor   = dly_rng.flag;
            out_over  = dly_rng.over;
            out_under = dly_rng.under;
            out_valid = run;
        end
    end

    p_no_dual_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_over && out_under));

    p_over_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_over || out_under) |-> out_oor);

    p_refill_after_pd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_dn) |-> !out_valid);

    p_pd_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> (!out_valid || !$past(pwr_dn)));

endmodule

// File: tb/sim_adc_out_fmt.sv
`timescale 1ns/1ps
module sim_adc_out_fmt;
    localparam int DW  = 12;
    localparam int LAT = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] code = '0;
    logic          oor = 1'b0;
    logic [1:0]    fsel = 2'b00;
    logic          pd = 1'b0;
    logic [DW-1:0] out_code;
    logic          out_oor, out_over, out_under, out_valid;

    adc_out_fmt #(.DW(DW), .LAT(LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .core_code(code), .core_oor(oor),
        .fmt_sel(fsel), .pwr_dn(pd), .out_code(out_code), .out_oor(out_oor),
        .out_over(out_over), .out_under(out_under), .out_valid(out_valid)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int unsigned ecount = 0;
    int fill = 0;
    logic [DW-1:0] r_word [8];
    logic [2:0]    r_rng  [8];
    logic [1:0]    r_fmt  [8];

    function automatic logic [DW-1:0] enc(logic [DW-1:0] b, logic [1:0] f);
        case (f)
            2'b01:   return {~b[DW-1], b[DW-2:0]};
            2'b10:   return b ^ (b >> 1);
            default: return b;
        endcase
    endfunction

    function automatic string ftag(logic [1:0] f);
        case (f)
            2'b01:   return "R3";
            2'b10:   return "R4";
            2'b11:   return "R5";
            default: return "R2";
        endcase
    endfunction

    // bench model of capture and fill count
    always @(posedge clk) begin
        int idx;
        idx = int'(ecount % 8);
        r_word[idx] = enc(code, fsel);
        r_rng[idx]  = {oor, oor & code[DW-1], oor & ~code[DW-1]};
        r_fmt[idx]  = fsel;
        ecount++;
        if (!rst_n || pd) fill = 0;
        else if (fill < LAT) fill++;
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_ports();
        logic [31:0] all_out;
        all_out = {15'd0, out_code, out_oor, out_over, out_under, out_valid};
        if (!rst_n) begin
            chk("R1 reset outputs", all_out, 32'd0);
        end else if (pd) begin
            chk("R10 power-down outputs", all_out, 32'd0);
        end else begin
            chk("R9 R11 valid strobe", {31'd0, out_valid}, {31'd0, fill >= LAT});
            if (fill >= LAT) begin
                int j;
                j = int'((ecount + 3) % 8);
                chk({ftag(r_fmt[j]), " R6 R7 word"}, {20'd0, out_code}, {20'd0, r_word[j]});
                chk("R8 R12 range bits", {29'd0, out_oor, out_over, out_under},
                    {29'd0, r_rng[j]});
            end
        end
    endtask

    task automatic step(logic p, logic [1:0] f, logic [DW-1:0] c, logic o);
        @(negedge clk);
        check_ports();
        pd = p; fsel = f; code = c; oor = o;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        // R1: held in reset
        repeat (3) step(1'b0, 2'b00, 12'hFFF, 1'b1);
        rst_n = 1'b1;
        // R2 / R9: corners in offset binary while filling and after
        step(1'b0, 2'b00, 12'd4095, 1'b0);
        step(1'b0, 2'b00, 12'd2048, 1'b0);
        step(1'b0, 2'b00, 12'd2047, 1'b0);
        step(1'b0, 2'b00, 12'd0,    1'b0);
        step(1'b0, 2'b00, 12'd4095, 1'b1);
        step(1'b0, 2'b00, 12'd0,    1'b1);
        // R3, R4, R5 corners, R8 with recoded formats
        for (int f = 1; f < 4; f++) begin
            step(1'b0, 2'(f), 12'd4095, 1'b1);
            step(1'b0, 2'(f), 12'd2048, 1'b0);
            step(1'b0, 2'(f), 12'd2047, 1'b0);
            step(1'b0, 2'(f), 12'd0,    1'b1);
            step(1'b0, 2'(f), 12'h555,  1'b0);
        end
        // R7: format alternates every sample
        for (int i = 0; i < 16; i++) step(1'b0, 2'(i % 3), 12'hA5C ^ 12'(i), 1'b0);
        // R10 / R11: directed power-down and refill
        repeat (3) step(1'b1, 2'b01, 12'h800, 1'b1);
        for (int i = 0; i < 8; i++) step(1'b0, 2'b10, 12'(i * 300), 1'b0);
        step(1'b1, 2'b00, 12'h123, 1'b0);
        for (int i = 0; i < 8; i++) step(1'b0, 2'b01, 12'(4095 - i), 1'b1);
        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            logic [DW-1:0] c;
            logic p, o;
            c = DW'($urandom);
            if ($urandom % 8 == 0) c = ($urandom % 2 == 0) ? '0 : '1;
            o = ((c == '0) || (c == '1)) ? 1'($urandom) : 1'b0;
            p = ($urandom % 24 == 0);
            step(p, 2'($urandom), c, o);
        end
        repeat (8) step(1'b0, 2'b00, 12'h3C3, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule